// File: doc/BRIEF.md
# Shared-Memory Row Access Hazard Guard

This block sits between a host processor and a shared packet memory. It holds a row data register and a row address register that stage whole-row transfers in both directions. The host starts a transfer with a row read or row write command strobe. The memory-side sequencer reports back with a completion handshake. While a read is still outstanding, the row data register holds old contents. While a write is outstanding, the register contents have not yet reached memory.

The guard records both outstanding states. It raises a single-cycle processor error pulse when the host acts too early. Four hazards are covered:

- reading the row data register while a read is outstanding;
- writing the row data register while a write is outstanding;
- writing the row address register while a write is outstanding;
- requesting a packet transmit while a write is outstanding.

Writes caught by a hazard are discarded, so the staged row and address reach memory unchanged. A sticky cause register records which hazard or hazards occurred. The host reads it through the same register port and clears it by writing ones.

Top module: `row_hazard_guard`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: the row data register, the row address register, the cause register, `proc_err`, `pkt_xmit`, and both outstanding states. No host action reports an error until a command is issued.
- R2: `cmd_rd_row` makes a read outstanding until `mem_rd_done`. On `mem_rd_done`, `mem_rd_data` is loaded into the row data register. After that, a read of select 0 returns the loaded value with no error.
- R3: Row read hazard. A host read of select 0 while a read is outstanding returns the previous row data in the same cycle. It raises `proc_err` for exactly the following cycle and sets cause bit 0.
- R4: Row write hazard. A host write of select 0 while a write is outstanding (from `cmd_wr_row` until `mem_wr_done`) leaves the row data register unchanged. It raises `proc_err` in the following cycle and sets cause bit 1.
- R5: Transmit hazard. `cmd_xmit` while a write is outstanding does not assert `pkt_xmit`. It raises `proc_err` in the following cycle and sets cause bit 2. With no write outstanding, `pkt_xmit` follows `cmd_xmit` in the same cycle and no error is raised.
- R6: Address hazard. A host write of select 1 while a write is outstanding leaves the row address register unchanged. It raises `proc_err` in the following cycle and sets cause bit 3.
- R7: Once `mem_wr_done` has been seen, writes to select 0 and select 1 take effect with no error.
- R8: Several hazards in one cycle produce one `proc_err` pulse of one cycle, and every matching cause bit is set.
- R9: Cause bits are sticky. A host write of select 2 clears each cause bit whose `wdata` bit is 1. A hazard setting a bit in the same cycle wins over the clear.
- R10: Host reads of `rdata` are combinational and follow `reg_sel`:
  - select 0: row data;
  - select 1: zero-extended address;
  - select 2: zero-extended 4-bit cause;
  - select 3: zero.
- R11: The memory-side outputs follow the host and the registers combinationally. `mem_rd_req` equals `cmd_rd_row`, `mem_wr_req` equals `cmd_wr_row`, `mem_addr` equals the row address register, and `mem_wdata` equals the row data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_rd_row | input | 1 | Host row read command strobe |
| cmd_wr_row | input | 1 | Host row write command strobe |
| cmd_xmit | input | 1 | Host packet transmit command strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 address, 2 cause |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Host read data |
| mem_rd_req | output | 1 | Row read request to the sequencer |
| mem_wr_req | output | 1 | Row write request to the sequencer |
| mem_addr | output | ADDR_W | Row address to the sequencer |
| mem_wdata | output | DATA_W | Row data to the sequencer |
| mem_rd_data | input | DATA_W | Row data returned by the sequencer |
| mem_rd_done | input | 1 | Read completion handshake |
| mem_wr_done | input | 1 | Write completion handshake |
| pkt_xmit | output | 1 | Accepted transmit request |
| proc_err | output | 1 | Processor error event pulse |

## Verification
The hardest situation to reach is several hazards landing in the same cycle as a cause-clear write, because it needs a write outstanding and several host strobes driven together.

The bench holds the memory model's write completion back for a configurable number of cycles. Inside that window it drives the combinations it needs:

- a transmit with an address write, checking for one error pulse and two cause bits;
- a transmit with a clear-all write to the cause register, checking that the new bit survives the clear.

The no-overwrite cases are checked by reading the data and address registers back through the host port after the completion arrives.

// File: rtl/rhg_pkg.sv
// Package: shared select codes and cause bit positions for the row hazard guard.
// Assumes a 2-bit host register select.
package rhg_pkg;
    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_CAUSE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int CAUSE_W     = 4;
    localparam int CB_RD_EARLY = 0;
    localparam int CB_WR_EARLY = 1;
    localparam int CB_XMIT     = 2;
    localparam int CB_ADDR     = 3;
endpackage

// File: rtl/rhg_pend_flags.sv
// Module: outstanding-state tracker.
// Keeps one flag per transfer direction: set by the command strobe, cleared
// by the matching completion. A command in the same cycle as a completion
// keeps the flag set. Assumes single-cycle strobes.
module rhg_pend_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] start,
    input  logic [N_FLAGS-1:0] done,
    output logic [N_FLAGS-1:0] pend
);
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        // Set on command, clear on completion, command wins.
        always_ff @(posedge clk) begin
            if (!rst_n)           pend[g] <= 1'b0;
            else if (start[g])    pend[g] <= 1'b1;
            else if (done[g])     pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rhg_hazard.sv
// Module: combinational hazard classifier.
// Decodes host strobes against the outstanding states. Produces one hazard
// bit per cause, the write enables that survive blocking, and the accepted
// transmit. Assumes at most one register access per cycle.
module rhg_hazard
    import rhg_pkg::*;
(
    input  logic               rd_pend,
    input  logic               wr_pend,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic               cmd_xmit,
    output logic [CAUSE_W-1:0] haz,
    output logic               data_we,
    output logic               addr_we,
    output logic               cause_we,
    output logic               xmit_ok
);
    logic sel_data, sel_addr, sel_cause;

    // Decode the register select.
    always_comb begin
        sel_data  = (reg_sel == SEL_DATA);
        sel_addr  = (reg_sel == SEL_ADDR);
        sel_cause = (reg_sel == SEL_CAUSE);
    end

    // Classify each premature access and gate the blocked updates.
    always_comb begin
        haz              = '0;
        haz[CB_RD_EARLY] = reg_rd && sel_data && rd_pend;
        haz[CB_WR_EARLY] = reg_wr && sel_data && wr_pend;
        haz[CB_XMIT]     = cmd_xmit && wr_pend;
        haz[CB_ADDR]     = reg_wr && sel_addr && wr_pend;
        data_we          = reg_wr && sel_data && !wr_pend;
        addr_we          = reg_wr && sel_addr && !wr_pend;
        cause_we         = reg_wr && sel_cause;
        xmit_ok          = cmd_xmit && !wr_pend;
    end
endmodule

// File: rtl/rhg_cause.sv
// Module: sticky cause register and processor error pulse.
// A hazard sets its bit; a host write clears the bits given as ones; setting
// wins over clearing. The error pulse follows any hazard by one cycle.
module rhg_cause
    import rhg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] haz,
    input  logic               clr_we,
    input  logic [CAUSE_W-1:0] clr_mask,
    output logic [CAUSE_W-1:0] cause,
    output logic               proc_err
);
    logic [CAUSE_W-1:0] clr_bits;

    // Bits removed by a clear write this cycle.
    always_comb clr_bits = clr_we ? clr_mask : '0;

    // Update the sticky causes and the one-cycle error event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause    <= '0;
            proc_err <= 1'b0;
        end else begin
            cause    <= (cause & ~clr_bits) | haz;
            proc_err <= |haz;
        end
    end

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        proc_err |-> (cause != '0));                            // R8
    AST_HAZ_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (haz != '0) |=> ((cause & $past(haz)) == $past(haz)));   // R9
endmodule

// File: rtl/rhg_regs.sv
// Module: row data and row address staging registers.
// Returning read data has priority over a host write to the data register.
// Enables arrive already gated by the hazard classifier.
module rhg_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    input  logic              load_rd,
    input  logic [DATA_W-1:0] load_data,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [DATA_W-1:0] row_data,
    output logic [ADDR_W-1:0] row_addr
);
    // Row data: memory return first, else accepted host write.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_data <= '0;
        else if (load_rd) row_data <= load_data;
        else if (data_we) row_data <= data_in;
    end

    // Row address: accepted host write only.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_addr <= '0;
        else if (addr_we) row_addr <= addr_in;
    end
endmodule

// File: rtl/row_hazard_guard.sv
// Module: top of the row access hazard guard.
// Ties the outstanding-state tracker, hazard classifier, cause register and
// staging registers together, and drives the host read mux and memory-side
// requests. Assumes ADDR_W <= DATA_W and CAUSE_W <= DATA_W.
module row_hazard_guard
    import rhg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rd_row,
    input  logic              cmd_wr_row,
    input  logic              cmd_xmit,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_done,
    input  logic              mem_wr_done,
    output logic              pkt_xmit,
    output logic              proc_err
);
    localparam int IDX_RD = 0;
    localparam int IDX_WR = 1;

    logic [1:0]         pend;
    logic               rd_pend, wr_pend;
    logic [CAUSE_W-1:0] haz, cause;
    logic               data_we, addr_we, cause_we, xmit_ok;
    logic [DATA_W-1:0]  row_data;
    logic [ADDR_W-1:0]  row_addr;

    rhg_pend_flags #(.N_FLAGS(2)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .start ({cmd_wr_row, cmd_rd_row}),
        .done  ({mem_wr_done, mem_rd_done}),
        .pend  (pend)
    );

    // Name the two outstanding states.
    always_comb begin
        rd_pend = pend[IDX_RD];
        wr_pend = pend[IDX_WR];
    end

    rhg_hazard u_haz (
        .rd_pend  (rd_pend),
        .wr_pend  (wr_pend),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .cmd_xmit (cmd_xmit),
        .haz      (haz),
        .data_we  (data_we),
        .addr_we  (addr_we),
        .cause_we (cause_we),
        .xmit_ok  (xmit_ok)
    );

    rhg_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .haz      (haz),
        .clr_we   (cause_we),
        .clr_mask (wdata[CAUSE_W-1:0]),
        .cause    (cause),
        .proc_err (proc_err)
    );

    rhg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we   (data_we),
        .data_in   (wdata),
        .load_rd   (mem_rd_done),
        .load_data (mem_rd_data),
        .addr_we   (addr_we),
        .addr_in   (wdata[ADDR_W-1:0]),
        .row_data  (row_data),
        .row_addr  (row_addr)
    );

    // Host read mux; unused select returns zero.
    always_comb begin
        case (reg_sel)
            SEL_DATA:  rdata = row_data;
            SEL_ADDR:  rdata = DATA_W'(row_addr);
            SEL_CAUSE: rdata = DATA_W'(cause);
            default:   rdata = '0;
        endcase
    end

    // Memory-side requests and accepted transmit.
    always_comb begin
        mem_rd_req = cmd_rd_row;
        mem_wr_req = cmd_wr_row;
        mem_addr   = row_addr;
        mem_wdata  = row_data;
        pkt_xmit   = xmit_ok;
    end

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_DATA && wr_pend && !mem_rd_done) |=> $stable(row_data)); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_ADDR && wr_pend) |=> $stable(row_addr));                 // R6
    AST_XMIT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_xmit && wr_pend) |=> proc_err);                                               // R5
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_done && !cmd_rd_row) |=> !rd_pend);                                        // R2
    AST_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_DATA && rd_pend) |=> proc_err);                          // R3
endmodule

// File: tb/sim_row_hazard_guard.sv
module sim_row_hazard_guard;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam int MEM_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_rd_row = 0, cmd_wr_row = 0, cmd_xmit = 0, reg_rd = 0, reg_wr = 0;
    logic [1:0] reg_sel = 0;
    logic [DW-1:0] wdata = 0, mem_rd_data = 0;
    logic mem_rd_done = 0, mem_wr_done = 0;
    logic [DW-1:0] rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic mem_rd_req, mem_wr_req, pkt_xmit, proc_err;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    row_hazard_guard #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_rd_row(cmd_rd_row), .cmd_wr_row(cmd_wr_row),
        .cmd_xmit(cmd_xmit), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd_data(mem_rd_data),
        .mem_rd_done(mem_rd_done), .mem_wr_done(mem_wr_done), .pkt_xmit(pkt_xmit),
        .proc_err(proc_err)
    );

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cmd_rd_row = 0; cmd_wr_row = 0; cmd_xmit = 0; reg_rd = 0; reg_wr = 0;
        mem_rd_done = 0; mem_wr_done = 0;
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [DW-1:0] d);
        reg_sel = sel; wdata = d; reg_wr = 1; cyc(); idle();
    endtask

    function automatic logic [DW-1:0] peek(input logic [1:0] sel);
        reg_sel = sel;
        return 'x;
    endfunction

    task automatic rd(input logic [1:0] sel, output logic [DW-1:0] v);
        reg_sel = sel; #1; v = rdata;
    endtask

    task automatic wr_complete();
        repeat (MEM_LAT) cyc();
        mem_wr_done = 1; cyc(); idle();
    endtask

    task automatic clear_cause();
        host_wr(2'd2, 32'hF);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(2'd0, v); chk(v, 0, "R1 data reset");
        rd(2'd1, v); chk(v, 0, "R1 addr reset");
        rd(2'd2, v); chk(v, 0, "R1 cause reset");
        chk(proc_err, 0, "R1 err reset");
        chk(pkt_xmit, 0, "R1 xmit reset");
    endtask

    task automatic t_sel_and_mem();
        logic [DW-1:0] v;
        host_wr(2'd0, 32'hA5A5_0001);
        host_wr(2'd1, 32'h0000_0ABC);
        chk(proc_err, 0, "R7 no error on idle writes");
        rd(2'd0, v); chk(v, 32'hA5A5_0001, "R10 select 0");
        rd(2'd1, v); chk(v, 32'h0000_0ABC, "R10 select 1");
        rd(2'd3, v); chk(v, 0, "R10 select 3");
        chk(mem_addr, 12'hABC, "R11 mem_addr");
        chk(mem_wdata, 32'hA5A5_0001, "R11 mem_wdata");
        cmd_wr_row = 1; #1;
        chk(mem_wr_req, 1, "R11 mem_wr_req");
        chk(mem_rd_req, 0, "R11 mem_rd_req idle");
        cyc(); idle();
        wr_complete();
    endtask

    task automatic t_read();
        logic [DW-1:0] v;
        cmd_rd_row = 1; #1; chk(mem_rd_req, 1, "R11 mem_rd_req"); cyc(); idle();
        reg_sel = 2'd0; reg_rd = 1; #1;
        chk(rdata, 32'hA5A5_0001, "R3 stale data while pending");
        cyc(); idle();
        chk(proc_err, 1, "R3 error pulse");
        rd(2'd2, v); chk(v, 32'h1, "R3 cause bit 0");
        cyc(); chk(proc_err, 0, "R3 pulse one cycle");
        repeat (MEM_LAT) cyc();
        mem_rd_data = 32'h1234_5678; mem_rd_done = 1; cyc(); idle();
        clear_cause();
        reg_sel = 2'd0; reg_rd = 1; #1;
        chk(rdata, 32'h1234_5678, "R2 loaded data");
        cyc(); idle();
        chk(proc_err, 0, "R2 no error after completion");
    endtask

    task automatic t_write_and_addr();
        logic [DW-1:0] v;
        cmd_wr_row = 1; cyc(); idle();
        host_wr(2'd0, 32'hDEAD_BEEF);
        chk(proc_err, 1, "R4 error pulse");
        rd(2'd2, v); chk(v, 32'h2, "R4 cause bit 1");
        rd(2'd0, v); chk(v, 32'h1234_5678, "R4 data kept");
        clear_cause();
        host_wr(2'd1, 32'h0000_0123);
        chk(proc_err, 1, "R6 error pulse");
        rd(2'd2, v); chk(v, 32'h8, "R6 cause bit 3");
        rd(2'd1, v); chk(v, 32'h0000_0ABC, "R6 address kept");
        wr_complete();
        clear_cause();
        host_wr(2'd0, 32'hDEAD_BEEF);
        chk(proc_err, 0, "R7 data write no error");
        host_wr(2'd1, 32'h0000_0123);
        rd(2'd0, v); chk(v, 32'hDEAD_BEEF, "R7 data accepted");
        rd(2'd1, v); chk(v, 32'h0000_0123, "R7 address accepted");
    endtask

    task automatic t_xmit();
        logic [DW-1:0] v;
        cmd_xmit = 1; #1; chk(pkt_xmit, 1, "R5 transmit accepted");
        cyc(); idle(); chk(proc_err, 0, "R5 no error when idle");
        cmd_wr_row = 1; cyc(); idle();
        cmd_xmit = 1; #1; chk(pkt_xmit, 0, "R5 transmit blocked");
        cyc(); idle(); chk(proc_err, 1, "R5 error pulse");
        rd(2'd2, v); chk(v, 32'h4, "R5 cause bit 2");
        clear_cause();
        cmd_xmit = 1; reg_wr = 1; reg_sel = 2'd1; wdata = 32'h55; cyc(); idle();
        chk(proc_err, 1, "R8 single pulse");
        rd(2'd2, v); chk(v, 32'hC, "R8 both causes");
        cyc(); chk(proc_err, 0, "R8 pulse ends");
        cmd_xmit = 1; reg_wr = 1; reg_sel = 2'd2; wdata = 32'hF; cyc(); idle();
        rd(2'd2, v); chk(v, 32'h4, "R9 set beats clear");
        host_wr(2'd2, 32'h0);
        rd(2'd2, v); chk(v, 32'h4, "R9 zero mask keeps bit");
        clear_cause();
        rd(2'd2, v); chk(v, 32'h0, "R9 cleared");
        wr_complete();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1; cyc();
        t_sel_and_mem();
        t_read();
        t_write_and_addr();
        t_xmit();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule